// File: doc/BRIEF.md
# Microwire Serial EEPROM Device Model

This block is a synthesizable stand-in for a serial EEPROM of 16-bit words that sits on a four-wire Microwire link. The link has chip select, serial clock, data in and data out. The model runs on a system clock. It brings the three link inputs into that clock domain through two-flop synchronisers. It acts on each rising edge of the serial clock while chip select is high.

An instruction is a start bit of 1, then a two-bit opcode, then an address sent MSB first. Writes carry a 16-bit data word after the address. When the opcode is 00, the top two address bits select one of four extended commands. These are enable programming, disable programming, erase the whole array and write one word to the whole array. The remaining address bits are ignored.

Programming begins when chip select falls and lasts a set number of system clocks. While the array is busy, raising chip select shows the status on data out: 0 while busy and 1 once programming is done. A controller can use the model to exercise its driver without analog timing.

Top module: `mw_eeprom`

## Requirements
- R1: Data-in zeros clocked before the first 1 are ignored. Dropping chip select at any point abandons a partial instruction: nothing is programmed and the next instruction needs a fresh start bit.
- R2: Opcode 10 (read) drives a 0 on data out once the last address bit is clocked in. Each following rising serial-clock edge then presents the next bit of the word, MSB first. After the LSB, further edges drive 0.
- R3: Opcode 01 (write), followed by the address and 16 data bits MSB first, stores that word at the address.
- R4: Opcode 11 (erase) sets the addressed word to 16'hFFFF.
- R5: Under opcode 00, address top bits 11 enable programming and 00 disable it. The other address bits are don't-care.
- R6: Under opcode 00, address top bits 10 erase every word to 16'hFFFF. Top bits 01 followed by 16 data bits write that word to every address.
- R7: Write, erase, erase-all and write-all have no effect unless an enable has been received since reset with no disable after it. Reset clears the enable.
- R8: Programming starts when chip select falls and lasts WRITE_CYCLES system clocks. With chip select high again, data out reads 0 while busy and 1 when done. The status stays until the next start bit.
- R9: After reset every word reads 16'hFFFF, and data out is 0 whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data into the device |
| do_o | output | 1 | Serial data out of the device, or ready status |

## Verification
A wrong decoder state shows up at data out within one serial-clock edge. A misaligned bit count shifts every read bit by one place, and a lost leading zero pushes the MSB early. A wrong enable flag or memory state appears only when a later read returns the word. A wrong busy flag appears as a missing or stuck 0 in the status window right after chip select rises again. For that reason, each programming step is followed by a status poll and a read of the touched addresses.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int ADDR_W       = 6,
  parameter int WRITE_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BW    = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_OP, S_ADR, S_DAT, S_RD, S_END} st_t;
  typedef enum logic [1:0] {P_WR, P_ER, P_ERAL, P_WRAL} pk_t;

  logic [2:0]        cs_p, sk_p;
  logic [1:0]        di_p;
  st_t               st;
  pk_t               pk;
  logic [4:0]        cnt;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] adr;
  logic [15:0]       dat, rdq;
  logic              rd_out, wen, pend, busy, stat;
  logic [BW-1:0]     bcnt;
  logic [15:0]       mem [DEPTH];

  wire cs_s    = cs_p[1];
  wire di_s    = di_p[1];
  wire sk_rise = sk_p[1] & ~sk_p[2];
  wire cs_fall = ~cs_p[1] & cs_p[2];
  wire [ADDR_W-1:0] adr_n = {adr[ADDR_W-2:0], di_s};
  wire [15:0]       dat_n = {dat[14:0], di_s};
  wire [1:0]        ext   = adr_n[ADDR_W-1 -: 2];

  assign do_o = cs_s & (stat ? ~busy : rd_out);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= '0; sk_p <= '0; di_p <= '0;
      st <= S_IDLE; pk <= P_WR; cnt <= '0; opc <= '0;
      adr <= '0; dat <= '0; rdq <= '0;
      rd_out <= 1'b0; wen <= 1'b0; pend <= 1'b0; busy <= 1'b0; stat <= 1'b0;
      bcnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
    end else begin
      cs_p <= {cs_p[1:0], cs_i};
      sk_p <= {sk_p[1:0], sk_i};
      di_p <= {di_p[0], di_i};
      if (!cs_s) begin
        st     <= S_IDLE;
        rd_out <= 1'b0;
      end else if (sk_rise) begin
        case (st)
          S_IDLE: if (di_s && !busy) begin
            st   <= S_OP;
            cnt  <= '0;
            stat <= 1'b0;
          end
          S_OP: begin
            opc <= {opc[0], di_s};
            if (cnt == 5'd1) begin st <= S_ADR; cnt <= '0; end
            else cnt <= cnt + 5'd1;
          end
          S_ADR: begin
            adr <= adr_n;
            if (cnt == 5'(ADDR_W - 1)) begin
              cnt <= '0;
              case (opc)
                2'b10: begin rdq <= mem[adr_n]; rd_out <= 1'b0; st <= S_RD; end
                2'b01: st <= S_DAT;
                2'b11: begin pend <= wen; pk <= P_ER; st <= S_END; end
                default: begin
                  case (ext)
                    2'b11: begin wen <= 1'b1; st <= S_END; end
                    2'b00: begin wen <= 1'b0; st <= S_END; end
                    2'b10: begin pend <= wen; pk <= P_ERAL; st <= S_END; end
                    default: st <= S_DAT;
                  endcase
                end
              endcase
            end else cnt <= cnt + 5'd1;
          end
          S_DAT: begin
            dat <= dat_n;
            if (cnt == 5'd15) begin
              pend <= wen;
              pk   <= (opc == 2'b01) ? P_WR : P_WRAL;
              st   <= S_END;
            end else cnt <= cnt + 5'd1;
          end
          S_RD: begin
            if (cnt == 5'd16) begin
              rd_out <= 1'b0;
              st     <= S_END;
            end else begin
              rd_out <= rdq[15];
              rdq    <= {rdq[14:0], 1'b0};
              cnt    <= cnt + 5'd1;
            end
          end
          default: ;
        endcase
      end

      if (cs_fall && pend && !busy) begin
        busy <= 1'b1;
        bcnt <= BW'(WRITE_CYCLES - 1);
        stat <= 1'b1;
        pend <= 1'b0;
      end else if (busy) begin
        if (bcnt == '0) begin
          busy <= 1'b0;
          case (pk)
            P_WR:   mem[adr] <= dat;
            P_ER:   mem[adr] <= 16'hFFFF;
            P_ERAL: for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
            default: for (int i = 0; i < DEPTH; i++) mem[i] <= dat;
          endcase
        end else bcnt <= bcnt - BW'(1);
      end
    end
  end

  a_r1_cs_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> st == S_IDLE);
  a_r2_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && $past(st) != S_RD) |-> !rd_out);
  a_r7_enabled_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wen);
  a_r8_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt < BW'(WRITE_CYCLES));
  a_r8_end_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_END && cs_s) |=> (st == S_END || !cs_p[1]));
endmodule

// File: tb/sim_mw_eeprom.sv
`timescale 1ns/1ps
module sim_mw_eeprom;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o;
  logic exp_do = 1'b0, chk_en = 1'b0, done = 1'b0;
  int checks = 0, errors = 0;
  string req = "R9";
  logic [15:0] m_mem [64];
  logic m_wen = 1'b0, m_stat = 1'b0;

  always #2.5 clk = ~clk;

  mw_eeprom u0 (.clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .do_o(do_o));

  always @(negedge clk) if (chk_en && !done) begin
    checks++;
    if (do_o !== exp_do) begin
      errors++;
      $display("FAIL %s: do_o=%b expected %b at %0t", req, do_o, exp_do, $time);
    end
  end

  task automatic pulse(input logic b, input logic e);
    chk_en = 0; di = b; sk = 0;
    repeat (8) @(posedge clk);
    sk = 1;
    repeat (6) @(posedge clk);
    exp_do = e; chk_en = 1;
    repeat (2) @(posedge clk);
    chk_en = 0;
  endtask

  task automatic cs_up(input logic e);
    chk_en = 0; sk = 0; cs = 1;
    repeat (6) @(posedge clk);
    exp_do = e; chk_en = 1;
    repeat (2) @(posedge clk);
    chk_en = 0;
  endtask

  task automatic cs_down();
    chk_en = 0; sk = 0; cs = 0;
    repeat (6) @(posedge clk);
    exp_do = 0; chk_en = 1;
    repeat (2) @(posedge clk);
    chk_en = 0;
  endtask

  task automatic hdr(input logic [1:0] op, input logic [5:0] a);
    pulse(1'b1, 1'b0); m_stat = 0;
    pulse(op[1], 1'b0); pulse(op[0], 1'b0);
    for (int i = 5; i >= 0; i--) pulse(a[i], 1'b0);
  endtask

  task automatic rd(input logic [5:0] a, input int lead, input string r);
    logic [15:0] w;
    req = r;
    cs_up(m_stat);
    for (int i = 0; i < lead; i++) pulse(1'b0, m_stat);
    hdr(2'b10, a);
    w = m_mem[a];
    for (int i = 15; i >= 0; i--) pulse(1'b0, w[i]);
    pulse(1'b0, 1'b0);
    cs_down();
  endtask

  task automatic prog(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d,
                      input string r);
    logic has_d, eff;
    req = r;
    has_d = (op == 2'b01) || (op == 2'b00 && a[5:4] == 2'b01);
    eff = m_wen && (op != 2'b00 || a[5:4] == 2'b10 || a[5:4] == 2'b01);
    cs_up(m_stat);
    hdr(op, a);
    if (has_d) for (int i = 15; i >= 0; i--) pulse(d[i], 1'b0);
    if (op == 2'b00 && a[5:4] == 2'b11) m_wen = 1;
    if (op == 2'b00 && a[5:4] == 2'b00) m_wen = 0;
    cs_down();
    if (eff) begin
      req = {r, "/R8"};
      cs_up(1'b0);
      chk_en = 0;
      repeat (60) @(posedge clk);
      exp_do = 1; chk_en = 1;
      repeat (2) @(posedge clk);
      chk_en = 0;
      m_stat = 1;
      cs_down();
      case (op)
        2'b01: m_mem[a] = d;
        2'b11: m_mem[a] = 16'hFFFF;
        default: for (int i = 0; i < 64; i++) m_mem[i] = (a[5:4] == 2'b10) ? 16'hFFFF : d;
      endcase
    end else begin
      cs_up(m_stat);
      cs_down();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) m_mem[i] = 16'hFFFF;
    repeat (5) @(posedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    req = "R9"; exp_do = 0; chk_en = 1;
    repeat (3) @(posedge clk);
    chk_en = 0;
    rd(6'd5, 0, "R9");
    rd(6'd63, 0, "R2");
    prog(2'b01, 6'd3, 16'hA5C3, "R7");
    rd(6'd3, 0, "R7");
    prog(2'b00, 6'b11_0101, 16'h0, "R5");
    prog(2'b01, 6'd3, 16'hA5C3, "R3");
    rd(6'd3, 2, "R3");
    prog(2'b01, 6'd63, 16'h1234, "R3");
    rd(6'd63, 0, "R2");
    prog(2'b01, 6'd0, 16'h8001, "R3");
    rd(6'd0, 0, "R2");
    prog(2'b11, 6'd3, 16'h0, "R4");
    rd(6'd3, 0, "R4");
    rd(6'd63, 0, "R4");
    req = "R1";
    cs_up(m_stat);
    pulse(1'b1, 1'b0); m_stat = 0;
    pulse(1'b0, 1'b0); pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0); pulse(1'b1, 1'b0); pulse(1'b1, 1'b0);
    cs_down();
    cs_up(1'b0);
    cs_down();
    rd(6'd63, 3, "R1");
    prog(2'b00, 6'b01_0011, 16'h5A5A, "R6");
    rd(6'd0, 0, "R6");
    rd(6'd17, 0, "R6");
    rd(6'd63, 0, "R6");
    prog(2'b00, 6'b10_0110, 16'h0, "R6");
    rd(6'd0, 0, "R6");
    rd(6'd40, 0, "R6");
    prog(2'b01, 6'd10, 16'h0F0F, "R3");
    prog(2'b00, 6'b00_1010, 16'h0, "R5");
    prog(2'b01, 6'd11, 16'h7777, "R7");
    prog(2'b11, 6'd10, 16'h0, "R7");
    prog(2'b00, 6'b10_0000, 16'h0, "R7");
    rd(6'd11, 0, "R7");
    rd(6'd10, 0, "R7");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule